// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core which older stores a load (or store) should wait for before it issues. A PC-indexed identity table assigns instructions that have caused ordering violations to a shared store set. A per-set table remembers the sequence numbers of that set's most recently inserted stores that have not yet issued. A separate tracker lists every store that has been inserted and has not yet issued. A lookup returns a valid-masked vector of sequence numbers to wait on.

Some loads can be marked strict when training finds the load and the store already in the same set. With the strict-wait input high, a strict load waits on every outstanding store in the tracker instead of only on its own set.

Squash removes younger in-flight stores, and clear wipes all learned and tracked state. All updates are registered. A lookup is combinational on the current state.

Top module: `store_set_predictor`

## Requirements
- R1: After reset, every lookup returns an all-zero `wait_valid`, `look_strict` is low and `trk_overflow` is low.
- R2: The identity-table index is `pc[SSIT_IDX_W+1:2]`. A lookup whose entry is invalid returns `wait_valid` all zero and `look_strict` low.
- R3: On a violation where neither entry is valid, both entries become valid. Both take set ID = store index mod 2^SET_W, and both strict bits are cleared.
- R4: On a violation where exactly one entry is valid, the invalid side takes the valid side's set ID with its strict bit cleared. The valid side is left unchanged.
- R5: On a violation where both entries are valid and the store's ID is larger, the store takes the load's ID and clears its strict bit. Otherwise the load takes the store's ID, and the load's strict bit is set exactly when the two IDs were equal. The side that is not written is left unchanged.
- R6: An insert whose store has a valid entry writes its sequence number into the lowest free slot of that set. If all slots are taken, it overwrites the slot named by that set's round-robin pointer, which starts at 0 and then advances. A non-strict lookup of a valid entry puts set slot i on `wait_valid[i]` and `wait_seq[i*SEQ_W +: SEQ_W]`, with all higher positions zero. Stores with an invalid entry do not enter the set table.
- R7: Every insert enters the lowest free tracker slot. A store issue (`iss_is_store`=1) removes matching sequence numbers from the tracker and from the store's set. An issue with `iss_is_store`=0 has no effect.
- R8: An insert while all tracker slots are full is dropped from the tracker but is still taken by the set table. `trk_overflow` is high for exactly the following cycle.
- R9: With `strict_en`=1 and the looked-up entry valid and strict, `look_strict` is 1. In that case `wait_valid` and `wait_seq` hold the tracker slots by position. With `strict_en`=0 the non-strict result of R6 is returned.
- R10: A squash removes every tracker entry and set slot whose sequence number is greater (unsigned) than `sq_seq`. Inserts, issues and violations in the same cycle are ignored.
- R11: A clear invalidates all identity entries, strict bits, set slots and tracker entries. It overrides every other operation in that cycle.
- R12: An operation presented in one cycle is visible on the lookup outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_en | input | 1 | Enables strict waiting for strict entries |
| ins_valid | input | 1 | Store insert request |
| ins_pc | input | PC_W | PC of inserted store |
| ins_seq | input | SEQ_W | Sequence number of inserted store |
| iss_valid | input | 1 | Issue notification |
| iss_is_store | input | 1 | Issued instruction is a store |
| iss_pc | input | PC_W | PC of issued instruction |
| iss_seq | input | SEQ_W | Sequence number of issued instruction |
| vio_valid | input | 1 | Violation training request |
| vio_store_pc | input | PC_W | PC of the offending store |
| vio_load_pc | input | PC_W | PC of the violating load |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Entries younger than this are removed |
| clr | input | 1 | Bulk clear |
| look_pc | input | PC_W | PC being looked up |
| wait_valid | output | TRK_N | Valid mask of returned sequence numbers |
| wait_seq | output | TRK_N*SEQ_W | Packed sequence numbers, position i at bits i*SEQ_W |
| look_strict | output | 1 | Lookup used the strict path |
| trk_overflow | output | 1 | Previous cycle's insert found the tracker full |

## Verification
The bench builds the block with a 16-entry identity table, four sets of two slots, a four-entry tracker and 8-bit sequence numbers. With sets this shallow, a third store in one set exercises round-robin replacement. A fourth outstanding store fills the tracker, so a fifth raises the overflow flag while the set table still accepts the store. Because there are only four sets, chosen PCs land in a common set and drive all three violation cases, including the equal-ID case that marks a load strict.

// File: rtl/stsp_pkg.sv
package stsp_pkg;

  typedef enum logic [1:0] {
    VIO_NEITHER    = 2'd0,
    VIO_LOAD_ONLY  = 2'd1,
    VIO_STORE_ONLY = 2'd2,
    VIO_BOTH       = 2'd3
  } vio_case_e;

  function automatic vio_case_e classify_vio(input logic ld_v, input logic st_v);
    case ({st_v, ld_v})
      2'b00:   return VIO_NEITHER;
      2'b01:   return VIO_LOAD_ONLY;
      2'b10:   return VIO_STORE_ONLY;
      default: return VIO_BOTH;
    endcase
  endfunction

endpackage

// File: rtl/stsp_ssit.sv
module stsp_ssit
  import stsp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int ID_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            vio_do,
  input  logic [PC_W-1:0] vio_st_pc,
  input  logic [PC_W-1:0] vio_ld_pc,
  input  logic [PC_W-1:0] look_pc,
  output logic            look_hit,
  output logic [ID_W-1:0] look_id,
  output logic            look_strict,
  input  logic [PC_W-1:0] ins_pc,
  output logic            ins_hit,
  output logic [ID_W-1:0] ins_id,
  input  logic [PC_W-1:0] iss_pc,
  output logic            iss_hit,
  output logic [ID_W-1:0] iss_id
);
  localparam int N = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] slot_of(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [ID_W-1:0] fresh_id(input logic [IDX_W-1:0] idx);
    return ID_W'(idx);
  endfunction

  logic [N-1:0]    ent_v, ent_s;
  logic [ID_W-1:0] ent_id [N];

  logic [IDX_W-1:0] si, li;
  logic             sv, lv;
  logic [ID_W-1:0]  sid, lid;
  vio_case_e        vcase;
  logic             st_we, ld_we, ld_wstrict;
  logic [ID_W-1:0]  st_wid, ld_wid;

  assign si    = slot_of(vio_st_pc);
  assign li    = slot_of(vio_ld_pc);
  assign sv    = ent_v[si];
  assign lv    = ent_v[li];
  assign sid   = ent_id[si];
  assign lid   = ent_id[li];
  assign vcase = classify_vio(lv, sv);

  always_comb begin
    st_we      = 1'b0;
    ld_we      = 1'b0;
    st_wid     = fresh_id(si);
    ld_wid     = fresh_id(si);
    ld_wstrict = 1'b0;
    if (vio_do) begin
      case (vcase)
        VIO_NEITHER: begin
          st_we = 1'b1;
          ld_we = 1'b1;
        end
        VIO_LOAD_ONLY: begin
          st_we  = 1'b1;
          st_wid = lid;
        end
        VIO_STORE_ONLY: begin
          ld_we  = 1'b1;
          ld_wid = sid;
        end
        default: begin
          if (sid > lid) begin
            st_we  = 1'b1;
            st_wid = lid;
          end else begin
            ld_we      = 1'b1;
            ld_wid     = sid;
            ld_wstrict = (sid == lid);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ent_v <= '0;
      ent_s <= '0;
    end else begin
      if (st_we) begin
        ent_v[si]  <= 1'b1;
        ent_id[si] <= st_wid;
        ent_s[si]  <= 1'b0;
      end
      if (ld_we) begin
        ent_v[li]  <= 1'b1;
        ent_id[li] <= ld_wid;
        ent_s[li]  <= ld_wstrict;
      end
    end
  end

  assign look_hit    = ent_v[slot_of(look_pc)];
  assign look_id     = ent_id[slot_of(look_pc)];
  assign look_strict = ent_s[slot_of(look_pc)];
  assign ins_hit     = ent_v[slot_of(ins_pc)];
  assign ins_id      = ent_id[slot_of(ins_pc)];
  assign iss_hit     = ent_v[slot_of(iss_pc)];
  assign iss_id      = ent_id[slot_of(iss_pc)];

  assert_vio_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_do && !clr) |=> (ent_v[$past(si)] && ent_v[$past(li)]));

  assert_tie_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_do && !clr && vcase == VIO_BOTH && sid == lid) |=> ent_s[$past(li)]);

  assert_store_larger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_do && !clr && vcase == VIO_BOTH && sid > lid)
      |=> (ent_id[$past(si)] == $past(lid) && !ent_s[$past(si)]));

  assert_join_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_do && !clr && vcase == VIO_STORE_ONLY)
      |=> (ent_id[$past(li)] == $past(sid) && !ent_s[$past(li)]));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ent_v == '0 && ent_s == '0));

endmodule

// File: rtl/stsp_lfst.sv
module stsp_lfst #(
  parameter int SET_W = 4,
  parameter int SLOTS = 4,
  parameter int SEQ_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   sq_do,
  input  logic [SEQ_W-1:0]       sq_seq,
  input  logic                   ins_do,
  input  logic [SET_W-1:0]       ins_set,
  input  logic [SEQ_W-1:0]       ins_seq,
  input  logic                   iss_do,
  input  logic [SET_W-1:0]       iss_set,
  input  logic [SEQ_W-1:0]       iss_seq,
  input  logic [SET_W-1:0]       rd_set,
  output logic [SLOTS-1:0]       rd_v,
  output logic [SLOTS*SEQ_W-1:0] rd_seq
);
  localparam int SETS = 1 << SET_W;
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  function automatic logic [SW-1:0] lowest_free(input logic [SLOTS-1:0] v);
    logic [SW-1:0] r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) if (!v[i]) r = SW'(i);
    return r;
  endfunction

  function automatic logic [SW-1:0] rr_next(input logic [SW-1:0] p);
    return (p == SW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [SLOTS-1:0] sv   [SETS];
  logic [SEQ_W-1:0] sseq [SETS][SLOTS];
  logic [SW-1:0]    vptr [SETS];

  logic [SLOTS-1:0] iss_hit, ins_after;
  logic             ins_full;
  logic [SW-1:0]    ins_slot;
  logic             any_v;

  always_comb begin
    for (int s = 0; s < SLOTS; s++)
      iss_hit[s] = iss_do && sv[iss_set][s] && (sseq[iss_set][s] == iss_seq);
  end

  assign ins_after = sv[ins_set] & ~((iss_set == ins_set) ? iss_hit : '0);
  assign ins_full  = &ins_after;
  assign ins_slot  = ins_full ? vptr[ins_set] : lowest_free(ins_after);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int t = 0; t < SETS; t++) begin
        sv[t]   <= '0;
        vptr[t] <= '0;
      end
    end else if (sq_do) begin
      for (int t = 0; t < SETS; t++)
        for (int s = 0; s < SLOTS; s++)
          if (sseq[t][s] > sq_seq) sv[t][s] <= 1'b0;
    end else begin
      for (int s = 0; s < SLOTS; s++)
        if (iss_hit[s]) sv[iss_set][s] <= 1'b0;
      if (ins_do) begin
        sv[ins_set][ins_slot]   <= 1'b1;
        sseq[ins_set][ins_slot] <= ins_seq;
        if (ins_full) vptr[ins_set] <= rr_next(vptr[ins_set]);
      end
    end
  end

  assign rd_v = sv[rd_set];
  for (genvar g = 0; g < SLOTS; g++) begin : g_pack
    assign rd_seq[g*SEQ_W +: SEQ_W] = sseq[rd_set][g];
  end

  always_comb begin
    any_v = 1'b0;
    for (int t = 0; t < SETS; t++) any_v = any_v | (|sv[t]);
  end

  assert_ins_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_do && !clr && !sq_do)
      |=> (sv[$past(ins_set)][$past(ins_slot)] &&
           sseq[$past(ins_set)][$past(ins_slot)] == $past(ins_seq)));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_v);

endmodule

// File: rtl/stsp_tracker.sv
module stsp_tracker #(
  parameter int N     = 32,
  parameter int SEQ_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               sq_do,
  input  logic [SEQ_W-1:0]   sq_seq,
  input  logic               ins_do,
  input  logic [SEQ_W-1:0]   ins_seq,
  input  logic               rem_do,
  input  logic [SEQ_W-1:0]   rem_seq,
  output logic [N-1:0]       out_v,
  output logic [N*SEQ_W-1:0] out_seq,
  output logic               overflow
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  function automatic logic [IW-1:0] lowest_free(input logic [N-1:0] v);
    logic [IW-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (!v[i]) r = IW'(i);
    return r;
  endfunction

  logic [N-1:0]     tv;
  logic [SEQ_W-1:0] tseq [N];
  logic             full;
  logic [IW-1:0]    ins_slot;
  logic [N-1:0]     rem_hit;

  assign full     = &tv;
  assign ins_slot = lowest_free(tv);

  always_comb begin
    for (int i = 0; i < N; i++) rem_hit[i] = rem_do && tv[i] && (tseq[i] == rem_seq);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tv       <= '0;
      overflow <= 1'b0;
    end else if (sq_do) begin
      overflow <= 1'b0;
      for (int i = 0; i < N; i++) if (tseq[i] > sq_seq) tv[i] <= 1'b0;
    end else begin
      overflow <= ins_do && full;
      for (int i = 0; i < N; i++) if (rem_hit[i]) tv[i] <= 1'b0;
      if (ins_do && !full) begin
        tv[ins_slot]   <= 1'b1;
        tseq[ins_slot] <= ins_seq;
      end
    end
  end

  assign out_v = tv;
  for (genvar g = 0; g < N; g++) begin : g_pack
    assign out_seq[g*SEQ_W +: SEQ_W] = tseq[g];
  end

  logic [SEQ_W-1:0] chk_thr;
  logic [N-1:0]     chk_young;
  always_ff @(posedge clk) chk_thr <= sq_seq;
  always_comb begin
    for (int i = 0; i < N; i++) chk_young[i] = tv[i] && (tseq[i] > chk_thr);
  end

  assert_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_do && !clr) |=> (chk_young == '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(ins_do && full && !clr && !sq_do));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tv == '0 && !overflow));

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W       = 32,
  parameter int SSIT_IDX_W = 10,
  parameter int SET_W      = 4,
  parameter int SLOTS      = 4,
  parameter int TRK_N      = 32,
  parameter int SEQ_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strict_en,
  input  logic                   ins_valid,
  input  logic [PC_W-1:0]        ins_pc,
  input  logic [SEQ_W-1:0]       ins_seq,
  input  logic                   iss_valid,
  input  logic                   iss_is_store,
  input  logic [PC_W-1:0]        iss_pc,
  input  logic [SEQ_W-1:0]       iss_seq,
  input  logic                   vio_valid,
  input  logic [PC_W-1:0]        vio_store_pc,
  input  logic [PC_W-1:0]        vio_load_pc,
  input  logic                   sq_valid,
  input  logic [SEQ_W-1:0]       sq_seq,
  input  logic                   clr,
  input  logic [PC_W-1:0]        look_pc,
  output logic [TRK_N-1:0]       wait_valid,
  output logic [TRK_N*SEQ_W-1:0] wait_seq,
  output logic                   look_strict,
  output logic                   trk_overflow
);
  logic op_ok, sq_do, ins_do, iss_store, vio_do;
  logic look_hit, look_s, ins_hit, iss_hit, use_strict;
  logic [SET_W-1:0] look_id, ins_id, iss_id;
  logic [SLOTS-1:0] lf_v;
  logic [SLOTS*SEQ_W-1:0] lf_seq;
  logic [TRK_N-1:0] trk_v;
  logic [TRK_N*SEQ_W-1:0] trk_seq;

  assign op_ok     = !clr && !sq_valid;
  assign sq_do     = sq_valid && !clr;
  assign ins_do    = ins_valid && op_ok;
  assign iss_store = iss_valid && iss_is_store && op_ok;
  assign vio_do    = vio_valid && op_ok;

  stsp_ssit #(.PC_W(PC_W), .IDX_W(SSIT_IDX_W), .ID_W(SET_W)) u_ssit (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .vio_do(vio_do), .vio_st_pc(vio_store_pc), .vio_ld_pc(vio_load_pc),
    .look_pc(look_pc), .look_hit(look_hit), .look_id(look_id), .look_strict(look_s),
    .ins_pc(ins_pc), .ins_hit(ins_hit), .ins_id(ins_id),
    .iss_pc(iss_pc), .iss_hit(iss_hit), .iss_id(iss_id)
  );

  stsp_lfst #(.SET_W(SET_W), .SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_lfst (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .sq_do(sq_do), .sq_seq(sq_seq),
    .ins_do(ins_do && ins_hit), .ins_set(ins_id), .ins_seq(ins_seq),
    .iss_do(iss_store && iss_hit), .iss_set(iss_id), .iss_seq(iss_seq),
    .rd_set(look_id), .rd_v(lf_v), .rd_seq(lf_seq)
  );

  stsp_tracker #(.N(TRK_N), .SEQ_W(SEQ_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .sq_do(sq_do), .sq_seq(sq_seq),
    .ins_do(ins_do), .ins_seq(ins_seq),
    .rem_do(iss_store), .rem_seq(iss_seq),
    .out_v(trk_v), .out_seq(trk_seq), .overflow(trk_overflow)
  );

  assign use_strict = strict_en && look_hit && look_s;

  always_comb begin
    wait_valid = '0;
    wait_seq   = '0;
    if (use_strict) begin
      wait_valid = trk_v;
      wait_seq   = trk_seq;
    end else if (look_hit) begin
      wait_valid[SLOTS-1:0]       = lf_v;
      wait_seq[SLOTS*SEQ_W-1:0]   = lf_seq;
    end
  end

  assign look_strict = use_strict;

  assert_strict_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    look_strict |-> (strict_en && look_hit));

  assert_miss_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !look_hit |-> (wait_valid == '0 && !look_strict));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (wait_valid == '0 && !trk_overflow));

endmodule

// File: tb/store_set_predictor_bench.sv
`timescale 1ns/1ps
module store_set_predictor_bench;
  localparam int PC_W = 16, IDXW = 4, SETW = 2, SLOTS = 2, TRKN = 4, SEQW = 8;

  logic clk = 0, rst_n = 0, strict_en = 1;
  logic ins_valid = 0, iss_valid = 0, iss_is_store = 0, vio_valid = 0, sq_valid = 0, clr = 0;
  logic [PC_W-1:0] ins_pc = 0, iss_pc = 0, vio_store_pc = 0, vio_load_pc = 0, look_pc = 0;
  logic [SEQW-1:0] ins_seq = 0, iss_seq = 0, sq_seq = 0;
  logic [TRKN-1:0] wait_valid;
  logic [TRKN*SEQW-1:0] wait_seq;
  logic look_strict, trk_overflow;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  store_set_predictor #(.PC_W(PC_W), .SSIT_IDX_W(IDXW), .SET_W(SETW), .SLOTS(SLOTS),
                        .TRK_N(TRKN), .SEQ_W(SEQW)) u_store_set_predictor (
    .clk(clk), .rst_n(rst_n), .strict_en(strict_en),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_seq(ins_seq),
    .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_pc(iss_pc), .iss_seq(iss_seq),
    .vio_valid(vio_valid), .vio_store_pc(vio_store_pc), .vio_load_pc(vio_load_pc),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .clr(clr), .look_pc(look_pc),
    .wait_valid(wait_valid), .wait_seq(wait_seq), .look_strict(look_strict),
    .trk_overflow(trk_overflow)
  );

  // op: 0 none, 1 insert(pa,sq), 2 store issue(pa,sq), 3 violation(store pa, load pb), 4 squash(sq)
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] pa;
    logic [15:0] pb;
    logic [7:0]  sq;
    logic [15:0] lpc;
    logic [3:0]  emask;
    logic        estr;
    logic [31:0] eseq;
    logic [3:0]  req;
  } row_t;

  // PCs: L1=0x10 (index 4), S1=0x24 (index 9, set 1), S2=0x08 (index 2)
  localparam row_t TBL [10] = '{
    '{3'd0, 16'h0000, 16'h0000, 8'd0,  16'h0010, 4'b0000, 1'b0, 32'h00000000, 4'd1},  // R1
    '{3'd1, 16'h0024, 16'h0000, 8'd5,  16'h0010, 4'b0000, 1'b0, 32'h00000000, 4'd2},  // R2
    '{3'd3, 16'h0024, 16'h0010, 8'd0,  16'h0010, 4'b0000, 1'b0, 32'h00000000, 4'd3},  // R3
    '{3'd1, 16'h0024, 16'h0000, 8'd7,  16'h0010, 4'b0001, 1'b0, 32'h00000007, 4'd6},  // R6
    '{3'd3, 16'h0024, 16'h0010, 8'd0,  16'h0010, 4'b0011, 1'b1, 32'h00000705, 4'd5},  // R5
    '{3'd1, 16'h0008, 16'h0000, 8'd9,  16'h0010, 4'b0111, 1'b1, 32'h00090705, 4'd9},  // R9
    '{3'd2, 16'h0024, 16'h0000, 8'd5,  16'h0010, 4'b0110, 1'b1, 32'h00090700, 4'd7},  // R7
    '{3'd3, 16'h0008, 16'h0010, 8'd0,  16'h0008, 4'b0001, 1'b0, 32'h00000007, 4'd4},  // R4
    '{3'd1, 16'h0008, 16'h0000, 8'd11, 16'h0008, 4'b0011, 1'b0, 32'h00000B07, 4'd6},  // R6
    '{3'd4, 16'h0000, 16'h0000, 8'd8,  16'h0008, 4'b0001, 1'b0, 32'h00000007, 4'd10}  // R10
  };

  task automatic idle();
    ins_valid = 0; iss_valid = 0; iss_is_store = 0; vio_valid = 0; sq_valid = 0; clr = 0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    idle();
  endtask

  task automatic do_ins(input logic [15:0] pc, input logic [7:0] s);
    @(negedge clk); ins_valid = 1; ins_pc = pc; ins_seq = s; finish_op();
  endtask

  task automatic do_iss(input logic [15:0] pc, input logic [7:0] s, input logic st);
    @(negedge clk); iss_valid = 1; iss_is_store = st; iss_pc = pc; iss_seq = s; finish_op();
  endtask

  task automatic do_vio(input logic [15:0] spc, input logic [15:0] lpc);
    @(negedge clk); vio_valid = 1; vio_store_pc = spc; vio_load_pc = lpc; finish_op();
  endtask

  task automatic do_sq(input logic [7:0] s);
    @(negedge clk); sq_valid = 1; sq_seq = s; finish_op();
  endtask

  task automatic check_look(input string tag, input logic [15:0] pc, input logic [3:0] em,
                            input logic es, input logic [31:0] eseq);
    bit bad;
    look_pc = pc;
    #1;
    checks++;
    bad = (wait_valid !== em) || (look_strict !== es);
    for (int i = 0; i < TRKN; i++)
      if (em[i] && wait_seq[i*SEQW +: SEQW] !== eseq[i*SEQW +: SEQW]) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s pc=%h: mask=%b exp %b strict=%b exp %b seq=%h exp %h",
               tag, pc, wait_valid, em, look_strict, es, wait_seq, eseq);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b exp %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    look_pc = 16'h0024; #1;
    check_bit("R1 overflow after reset", trk_overflow, 1'b0);
    check_look("R1 empty after reset", 16'h0024, 4'b0000, 1'b0, 32'h0);

    foreach (TBL[k]) begin
      case (TBL[k].op)
        3'd1: do_ins(TBL[k].pa, TBL[k].sq);
        3'd2: do_iss(TBL[k].pa, TBL[k].sq, 1'b1);
        3'd3: do_vio(TBL[k].pa, TBL[k].pb);
        3'd4: do_sq(TBL[k].sq);
        default: @(negedge clk);
      endcase
      check_look($sformatf("R%0d row %0d", TBL[k].req, k), TBL[k].lpc, TBL[k].emask,
                 TBL[k].estr, TBL[k].eseq);
    end

    // R9: strict disabled falls back to set result (L1 in set 1, slot0=7)
    strict_en = 0;
    check_look("R9 strict disabled", 16'h0010, 4'b0001, 1'b0, 32'h00000007);
    strict_en = 1;

    // R3: fresh pair, set = store index 3
    do_vio(16'h000C, 16'h0000);
    do_ins(16'h000C, 8'd30);
    check_look("R3 fresh set", 16'h0000, 4'b0001, 1'b0, 32'h0000001E);
    // R5: store ID 1 smaller than load ID 3, load joins set 1, not strict
    do_vio(16'h0024, 16'h0000);
    check_look("R5 load joins smaller", 16'h0000, 4'b0001, 1'b0, 32'h00000007);
    // R5: store ID 3 larger than load ID 1, store joins set 1, load keeps strict
    do_vio(16'h000C, 16'h0010);
    check_look("R5 store joins smaller", 16'h000C, 4'b0001, 1'b0, 32'h00000007);
    check_look("R5 load entry unchanged", 16'h0010, 4'b0011, 1'b1, 32'h0000071E);

    // R7: load issue has no effect on tracker
    do_iss(16'h0024, 8'd7, 1'b0);
    check_look("R7 load issue ignored", 16'h0010, 4'b0011, 1'b1, 32'h0000071E);

    // R6: round-robin replacement in set 1
    do_ins(16'h0024, 8'd20);
    do_ins(16'h0024, 8'd21);
    check_look("R6 victim slot0", 16'h0024, 4'b0011, 1'b0, 32'h00001415);
    // R8: tracker full, set still takes store in slot 1
    do_ins(16'h0024, 8'd22);
    check_bit("R8 overflow pulse", trk_overflow, 1'b1);
    check_look("R8 set still accepts", 16'h0024, 4'b0011, 1'b0, 32'h00001615);
    check_look("R8 tracker unchanged", 16'h0010, 4'b1111, 1'b1, 32'h1514071E);
    @(negedge clk);
    check_bit("R8 overflow one cycle", trk_overflow, 1'b0);

    // R7: store issue removes from set and tracker
    do_iss(16'h0024, 8'd21, 1'b1);
    check_look("R7 issue clears set slot", 16'h0024, 4'b0010, 1'b0, 32'h00001600);
    check_look("R7 issue clears tracker", 16'h0010, 4'b0111, 1'b1, 32'h0014071E);

    // R10: squash with a concurrent insert; insert ignored
    @(negedge clk);
    sq_valid = 1; sq_seq = 8'd25; ins_valid = 1; ins_pc = 16'h0024; ins_seq = 8'd26;
    finish_op();
    check_look("R10 squash tracker", 16'h0010, 4'b0110, 1'b1, 32'h00140700);
    check_look("R10 insert dropped", 16'h0024, 4'b0010, 1'b0, 32'h00001600);
    check_bit("R10 no overflow", trk_overflow, 1'b0);

    // R11: clear with a concurrent insert
    @(negedge clk);
    clr = 1; ins_valid = 1; ins_pc = 16'h0024; ins_seq = 8'd3;
    finish_op();
    check_look("R11 clear load", 16'h0010, 4'b0000, 1'b0, 32'h0);
    check_look("R11 clear store", 16'h0024, 4'b0000, 1'b0, 32'h0);
    // R12: all updates above became visible exactly one edge after the op cycle
    check_bit("R12 overflow idle", trk_overflow, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule